// File: doc/BRIEF.md
# BCD Time and Calendar Counter Chain

This block keeps the time of day and the calendar date in packed BCD. Every cycle in which the single-cycle `tick` enable is high, and the run bit is set, the chain advances by one second. Carries ripple through minutes, hours, day of week, day of month, month and a two-digit year. Month lengths and leap years decide when the date wraps. The hours byte carries its own format bit: it counts either 00-23, or 01-12 with an AM/PM flag.

A small synchronous register port lets a host write any field and read it back combinationally. Writes are masked so that bits with no meaning store 0. Three alarm latches hold seconds, minutes and hours. When an advance of the chain lands on a time equal to the latches, the block emits a single-cycle `alarmHit` pulse. Clock generation, serial access and interrupt routing are left to the blocks around it.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00; day of week, date and month read 0x01; the run bit reads 0; all three alarm latches read 0x00; `alarmHit` is low.
- R2: Register map on `regAddr`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control (bit 0 = run), 8 alarm seconds, 9 alarm minutes, 10 alarm hours. Seconds and minutes count in BCD from 00 to 59. Each one wraps to 00 and carries into the next field. One step happens for each cycle with `tick`=1, run=1 and `regWe`=0.
- R3: While the run bit is 0, ticks leave every field unchanged. Writing 1 to the run bit resumes counting.
- R4: With hours bit 7 = 0, hours count 00-23. Advancing from 23:59:59 gives 00:00:00 and carries one day.
- R5: With hours bit 7 = 1, bits 4:0 hold BCD hours 01-12 and bit 5 is PM (1) or AM (0). 11 advancing to 12 toggles PM. 12 advancing gives 01. 11 PM advancing to 12 AM carries one day. Bit 7 is kept by advances.
- R6: The day of week counts 1-7 and wraps from 7 to 1 on each day carry.
- R7: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. The wrap also advances the month. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: February ends at 29 when the year's value is divisible by 4 (00 counts), and at 28 otherwise.
- R9: Write masks are seconds 0x7F, minutes 0x7F, hours 0xBF, day of week 0x07, date 0x3F, month 0x1F, year 0xFF, control 0x01, alarm seconds 0x7F, alarm minutes 0x7F and alarm hours 0x3F. Masked-off bits read 0. Addresses 11-15 read 0x00 and ignore writes.
- R10: In a cycle with `regWe`=1, a tick does not advance the chain. The written field takes exactly the masked written value.
- R11: The alarm matches when seconds and minutes equal their latches and hours bits 5:0 equal alarm-hours bits 5:0. `alarmHit` is high for exactly one cycle, in the cycle after an advance produces a match. A match created by a host write gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 Hz advance enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register index for write and read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for `regAddr` |
| alarmHit | output | 1 | One-cycle alarm match pulse |

## Verification
Random legal dates and times are loaded with a fixed seed. They are biased toward 59 seconds, 59 minutes, the last hour of each format and the last day of a month, so that every carry path from seconds up to the year is taken in both hour formats and is compared with a model written in plain binary integers. Directed cases cover what random loads reach only rarely: the two February lengths, the century-style year 00, the 11 and 12 hour transitions in both halves of the day, a write landing on a tick cycle, and masked writes. The alarm is driven to a match by a tick and separately by a host write. This shows that only the first gives a pulse, and that alarm-hours bits 7:6 and the current format bit play no part in the compare.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  localparam int FIELD_CNT = 7;
  localparam int ALM_CNT   = 3;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CTRL = 7;
  localparam int IDX_ALM0 = 8;

  typedef struct packed {
    logic                 step;
    logic [FIELD_CNT-1:0] fieldWr;
    logic [ALM_CNT-1:0]   almWr;
    logic [7:0]           wdata;
  } clkStrobe_t;

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR:         return 8'hBF;
      IDX_DOW:          return 8'h07;
      IDX_DATE:         return 8'h3F;
      IDX_MON:          return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] almMask(input int idx);
    return (idx == 2) ? 8'h3F : 8'h7F;
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] lastDate(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_clock_ctrl.sv
module bcd_clock_ctrl
  import bcd_clock_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit RESET_RUN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output clkStrobe_t        strb,
  output logic              runQ
);

  logic [FIELD_CNT-1:0] fieldWr;
  logic [ALM_CNT-1:0]   almWr;
  logic                 ctrlWr;

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_fieldDec
    assign fieldWr[i] = regWe && (regAddr == ADDR_W'(i));
  end

  for (genvar i = 0; i < ALM_CNT; i++) begin : g_almDec
    assign almWr[i] = regWe && (regAddr == ADDR_W'(IDX_ALM0 + i));
  end

  assign ctrlWr = regWe && (regAddr == ADDR_W'(IDX_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN)       runQ <= RESET_RUN;
    else if (ctrlWr) runQ <= regWdata[0];
  end

  assign strb = '{step:    tick && runQ && !regWe,
                  fieldWr: fieldWr,
                  almWr:   almWr,
                  wdata:   regWdata};

endmodule

// File: rtl/bcd_clock_dp.sv
module bcd_clock_dp
  import bcd_clock_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  clkStrobe_t                 strb,
  output logic [FIELD_CNT-1:0][7:0]  timeQ
);

  logic [7:0] secQ, minQ, hrQ, dowQ, dateQ, monQ, yrQ;
  logic [7:0] hrNext, h12Inc, h24Inc, dateLast;
  logic [6:0] yrBin;
  logic       hrDayCarry, leapYr;
  logic       cMin, cHr, cDay, cMon, cYr;

  assign h12Inc = bcdInc({3'b000, hrQ[4:0]});
  assign h24Inc = bcdInc({2'b00, hrQ[5:0]});

  always_comb begin
    hrNext     = hrQ;
    hrDayCarry = 1'b0;
    if (hrQ[7]) begin
      if (hrQ[4:0] == 5'h12) begin
        hrNext = {2'b10, hrQ[5], 5'h01};
      end else if (hrQ[4:0] == 5'h11) begin
        hrNext     = {2'b10, ~hrQ[5], 5'h12};
        hrDayCarry = hrQ[5];
      end else begin
        hrNext = {2'b10, hrQ[5], h12Inc[4:0]};
      end
    end else begin
      if (hrQ[5:0] == 6'h23) begin
        hrNext     = 8'h00;
        hrDayCarry = 1'b1;
      end else begin
        hrNext = {2'b00, h24Inc[5:0]};
      end
    end
  end

  assign yrBin    = 7'({yrQ[7:4], 3'b000}) + 7'({yrQ[7:4], 1'b0}) + 7'(yrQ[3:0]);
  assign leapYr   = (yrBin[1:0] == 2'b00);
  assign dateLast = lastDate(monQ, leapYr);

  assign cMin = strb.step && (secQ == 8'h59);
  assign cHr  = cMin && (minQ == 8'h59);
  assign cDay = cHr && hrDayCarry;
  assign cMon = cDay && (dateQ == dateLast);
  assign cYr  = cMon && (monQ == 8'h12);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= 8'h00;
      minQ  <= 8'h00;
      hrQ   <= 8'h00;
      dowQ  <= 8'h01;
      dateQ <= 8'h01;
      monQ  <= 8'h01;
      yrQ   <= 8'h00;
    end else begin
      if (strb.fieldWr[IDX_SEC])  secQ <= strb.wdata & fieldMask(IDX_SEC);
      else if (strb.step)         secQ <= (secQ == 8'h59) ? 8'h00 : bcdInc(secQ);

      if (strb.fieldWr[IDX_MIN])  minQ <= strb.wdata & fieldMask(IDX_MIN);
      else if (cMin)              minQ <= (minQ == 8'h59) ? 8'h00 : bcdInc(minQ);

      if (strb.fieldWr[IDX_HOUR]) hrQ <= strb.wdata & fieldMask(IDX_HOUR);
      else if (cHr)               hrQ <= hrNext;

      if (strb.fieldWr[IDX_DOW])  dowQ <= strb.wdata & fieldMask(IDX_DOW);
      else if (cDay)              dowQ <= (dowQ == 8'h07) ? 8'h01 : dowQ + 8'h01;

      if (strb.fieldWr[IDX_DATE]) dateQ <= strb.wdata & fieldMask(IDX_DATE);
      else if (cDay)              dateQ <= (dateQ == dateLast) ? 8'h01 : bcdInc(dateQ);

      if (strb.fieldWr[IDX_MON])  monQ <= strb.wdata & fieldMask(IDX_MON);
      else if (cMon)              monQ <= (monQ == 8'h12) ? 8'h01 : bcdInc(monQ);

      if (strb.fieldWr[IDX_YEAR]) yrQ <= strb.wdata & fieldMask(IDX_YEAR);
      else if (cYr)               yrQ <= (yrQ == 8'h99) ? 8'h00 : bcdInc(yrQ);
    end
  end

  assign timeQ = {yrQ, monQ, dateQ, dowQ, hrQ, minQ, secQ};

endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
  import bcd_clock_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  clkStrobe_t              strb,
  input  logic [7:0]              secQ,
  input  logic [7:0]              minQ,
  input  logic [7:0]              hrQ,
  output logic [ALM_CNT-1:0][7:0] almQ,
  output logic                    alarmHit
);

  logic stepped;
  logic eqNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almQ <= '0;
    end else begin
      for (int i = 0; i < ALM_CNT; i++) begin
        if (strb.almWr[i]) almQ[i] <= strb.wdata & almMask(i);
      end
    end
  end

  assign eqNow = (secQ == almQ[0]) && (minQ == almQ[1]) &&
                 (hrQ[5:0] == almQ[2][5:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepped  <= 1'b0;
      alarmHit <= 1'b0;
    end else begin
      stepped  <= strb.step;
      alarmHit <= stepped && eqNow;
    end
  end

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit RESET_RUN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              alarmHit
);

  clkStrobe_t                strb;
  logic                      runQ;
  logic [FIELD_CNT-1:0][7:0] timeQ;
  logic [ALM_CNT-1:0][7:0]   almQ;

  bcd_clock_ctrl #(.ADDR_W(ADDR_W), .RESET_RUN(RESET_RUN)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .strb(strb), .runQ(runQ)
  );

  bcd_clock_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .timeQ(timeQ)
  );

  bcd_alarm_unit alm_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .secQ(timeQ[IDX_SEC]), .minQ(timeQ[IDX_MIN]), .hrQ(timeQ[IDX_HOUR]),
    .almQ(almQ), .alarmHit(alarmHit)
  );

  always_comb begin
    regRdata = 8'h00;
    if (regAddr < ADDR_W'(FIELD_CNT))         regRdata = timeQ[regAddr[2:0]];
    else if (regAddr == ADDR_W'(IDX_CTRL))    regRdata = {7'b0, runQ};
    else if (regAddr == ADDR_W'(IDX_ALM0))    regRdata = almQ[0];
    else if (regAddr == ADDR_W'(IDX_ALM0 + 1)) regRdata = almQ[1];
    else if (regAddr == ADDR_W'(IDX_ALM0 + 2)) regRdata = almQ[2];
  end

endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWdata,
  input logic [7:0]        regRdata,
  input logic              runQ,
  input logic              step,
  input logic [7:0]        secQ,
  input logic [7:0]        hrQ,
  input logic              alarmHit
);

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !regWe) |=> $stable(secQ));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && secQ == 8'h59) |=> (secQ == 8'h00));

  p_mode_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (hrQ[7] == $past(hrQ[7])));

  p_sec_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0)) |=> (secQ == ($past(regWdata) & 8'h7F)));

  p_dow_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(3)) |-> (regRdata[7:3] == 5'b0));

  p_alarm_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> !alarmHit);

endmodule

bind bcd_clock_core bcd_clock_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .runQ(runQ),
  .step(strb.step), .secQ(timeQ[0]), .hrQ(timeQ[2]), .alarmHit(alarmHit)
);

// File: tb/bcd_clock_core_tb_top.sv
`timescale 1ns/1ps
module bcd_clock_core_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       alarmHit;

  int total = 0;
  int bad = 0;
  int hits = 0;
  bit done = 1'b0;

  // reference state, plain integers
  int ms, mm, mh, mdow, mdt, mmo, myr;
  bit m12, mRun;

  bcd_clock_core dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .alarmHit(alarmHit)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rstN && alarmHit) hits++;

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int monLen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hourByte();
    int h12;
    if (!m12) return toBcd(mh);
    h12 = (mh % 12 == 0) ? 12 : mh % 12;
    return 8'h80 | ((mh >= 12) ? 8'h20 : 8'h00) | toBcd(h12);
  endfunction

  function automatic logic [7:0] expField(input int i);
    case (i)
      0: return toBcd(ms);
      1: return toBcd(mm);
      2: return hourByte();
      3: return toBcd(mdow);
      4: return toBcd(mdt);
      5: return toBcd(mmo);
      default: return toBcd(myr);
    endcase
  endfunction

  function automatic string fieldTag(input int i);
    if (i < 2) return "R2";
    if (i == 2) return m12 ? "R5" : "R4";
    if (i == 3) return "R6";
    return "R7";
  endfunction

  task automatic modelAdvance();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mdow = (mdow == 7) ? 1 : mdow + 1;
      mdt++;
      if (mdt > monLen(mmo, myr)) begin mdt = 1; mmo++; end
      if (mmo == 13) begin mmo = 1; myr = (myr + 1) % 100; end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (mRun) modelAdvance();
  endtask

  task automatic checkAll(input string over);
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), d);
      check((over.len() != 0) ? over : fieldTag(i), d, expField(i));
    end
  endtask

  task automatic setTime(input bit f12, input int h, input int m, input int s,
                         input int dw, input int dt, input int mo, input int yr);
    m12 = f12; mh = h; mm = m; ms = s; mdow = dw; mdt = dt; mmo = mo; myr = yr;
    wr(4'd0, toBcd(s));
    wr(4'd1, toBcd(m));
    wr(4'd2, hourByte());
    wr(4'd3, toBcd(dw));
    wr(4'd4, toBcd(dt));
    wr(4'd5, toBcd(mo));
    wr(4'd6, toBcd(yr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int base;
    void'($urandom(32'd4711));
    ms = 0; mm = 0; mh = 0; mdow = 1; mdt = 1; mmo = 1; myr = 0; m12 = 0; mRun = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkAll("R1");
    rd(4'd7, d);  check("R1", d, 8'h00);
    for (int i = 8; i < 11; i++) begin rd(4'(i), d); check("R1", d, 8'h00); end
    check("R1", {7'b0, alarmHit}, 8'h00);

    // R3 stopped chain ignores ticks
    repeat (3) tickOnce();
    rd(4'd0, d); check("R3", d, 8'h00);
    wr(4'd7, 8'h01); mRun = 1;
    rd(4'd7, d); check("R3", d, 8'h01);
    tickOnce();
    rd(4'd0, d); check("R3", d, 8'h01);

    // R4 R6 R7 full rollover in 24h format
    setTime(0, 23, 59, 59, 7, 31, 12, 99);
    tickOnce(); checkAll("");
    // R5 12h transitions
    setTime(1, 11, 59, 59, 2, 10, 6, 30); tickOnce(); checkAll("R5");
    setTime(1, 0, 59, 59, 2, 10, 6, 30);  tickOnce(); checkAll("R5");
    setTime(1, 12, 59, 59, 2, 10, 6, 30); tickOnce(); checkAll("R5");
    setTime(1, 23, 59, 59, 4, 30, 4, 30); tickOnce(); checkAll("R5");
    // R8 leap handling
    setTime(0, 23, 59, 59, 1, 28, 2, 24); tickOnce(); checkAll("R8");
    setTime(0, 23, 59, 59, 1, 29, 2, 24); tickOnce(); checkAll("R8");
    setTime(0, 23, 59, 59, 1, 28, 2, 23); tickOnce(); checkAll("R8");
    setTime(0, 23, 59, 59, 1, 28, 2, 0);  tickOnce(); checkAll("R8");
    // R7 30-day month
    setTime(0, 23, 59, 59, 3, 30, 4, 10); tickOnce(); checkAll("R7");

    // R9 masks and unused addresses
    wr(4'd3, 8'hFF); rd(4'd3, d); check("R9", d, 8'h07);
    wr(4'd0, 8'hFF); rd(4'd0, d); check("R9", d, 8'h7F);
    wr(4'd2, 8'hFF); rd(4'd2, d); check("R9", d, 8'hBF);
    wr(4'd10, 8'hFF); rd(4'd10, d); check("R9", d, 8'h3F);
    wr(4'd12, 8'hFF); rd(4'd12, d); check("R9", d, 8'h00);
    wr(4'd7, 8'hFF); rd(4'd7, d); check("R9", d, 8'h01);

    // R10 write in a tick cycle wins, no advance
    setTime(0, 5, 6, 7, 1, 1, 1, 1);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd0; regWdata = 8'h59; tick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; tick = 1'b0; ms = 59;
    checkAll("R10");

    // R11 alarm behaviour
    setTime(0, 0, 0, 4, 1, 1, 1, 0);
    wr(4'd8, 8'h05); wr(4'd9, 8'h00); wr(4'd10, 8'hC0);
    rd(4'd10, d); check("R11", d, 8'h00);
    base = hits;
    tickOnce(); repeat (3) @(negedge clk);
    check("R11", 8'(hits - base), 8'd1);
    tickOnce(); repeat (3) @(negedge clk);
    check("R11", 8'(hits - base), 8'd1);
    wr(4'd0, 8'h05); ms = 5; repeat (3) @(negedge clk);
    check("R11", 8'(hits - base), 8'd1);
    setTime(1, 13, 0, 4, 1, 1, 1, 0);
    wr(4'd10, 8'h21);
    base = hits;
    tickOnce(); repeat (3) @(negedge clk);
    check("R11", 8'(hits - base), 8'd1);
    wr(4'd10, 8'h01);
    setTime(1, 13, 0, 4, 1, 1, 1, 0);
    base = hits;
    tickOnce(); repeat (3) @(negedge clk);
    check("R11", 8'(hits - base), 8'd0);

    // random legal loads biased to carries
    for (int it = 0; it < 40; it++) begin
      int s, m, h, mo, yr, dt, n;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      m  = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
      mo = 1 + $urandom % 12;
      yr = $urandom % 100;
      dt = ($urandom % 2) ? monLen(mo, yr) : 1 + $urandom % monLen(mo, yr);
      setTime(1'($urandom % 2), h, m, s, 1 + $urandom % 7, dt, mo, yr);
      n = 1 + $urandom % 2;
      for (int k = 0; k < n; k++) tickOnce();
      checkAll("");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule